// File: doc/BRIEF.md
# Segment Line Loader with Cascaded Chip Select

This block gathers one display line of 160 columns from a shared parallel data bus and turns it into a 2-bit drive-level code per column. A host clocks words onto the bus with a slow shift clock. Each word is 4 bits wide or 8 bits wide, chosen by a width pin. The block fills its data latch from one end of the line or the other, set by a fill-direction pin. A latch pulse then copies the whole line into a line latch that drives the level encoder.

Several loaders can share one bus as a chain. A loader takes bus words only once its enable input has been seen low. It counts its own 160 bits, then stops listening and drives its enable output low for one shift-clock period. That low period selects the next loader in the chain. The shift clock, the latch pulse and the bus all come from another clock domain. The block samples them on its own system clock and acts on the falling edges of the shift clock and the latch pulse.

Top module: `seg_line_loader`

## Requirements
- R1: With `width_sel` low, a line takes 40 shift-clock falls and uses `data_in[3:0]` only. With it high, a line takes 20 falls and uses all 8 bits. The end of the line shows as the enable output pulse after the last word.
- R2: A bus word is taken at the falling edge of `shift_clk`. The value on the bus at the rising edge has no effect.
- R3: With `fill_up` low, filling starts at the top column. Column c is `line_bits[c-1]`. In 8-bit mode, word k (from 0) puts data bit j at column 153-8k+j. In 4-bit mode, word k puts data bit j at column 157-4k+j.
- R4: With `fill_up` high, filling starts at column 1. In 8-bit mode, word k puts data bit j at column 8k+8-j. In 4-bit mode, word k puts data bit j at column 4k+4-j.
- R5: With `fill_up` low, `link_b_in` is the enable input and side A drives the enable output (`link_a_oe`=1, `link_b_oe`=0). With `fill_up` high, the two sides swap roles. A side that is not the output holds its `_out` at 1.
- R6: A latch-pulse fall resets the capture count and the selection. After a full line has been read, further shift-clock falls leave the data latch unchanged until the next latch pulse.
- R7: The enable output is high. It goes low at the shift-clock fall that completes the line, and it returns high at the next shift-clock fall.
- R8: At a fall of `line_pulse`, all 160 data-latch bits are copied into `line_bits` together. At other times `line_bits` holds its value.
- R9: While `disp_on` is low, every code is 3 and `line_bits` stays cleared. The data latch still loads, so the next latch pulse after `disp_on` returns high shows the line loaded while the display was off.
- R10: With `disp_on` high, the code of a column is set by `frame_inv` and the column bit, written as (frame_inv, bit). (0,0) gives 2, (0,1) gives 3, (1,0) gives 1 and (1,1) gives 0. Code 0 is the highest drive level and code 3 is the lowest.
- R11: If the enable input stays high from the latch pulse onward, shift-clock falls capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| width_sel | input | 1 | 0: 4-bit words, 1: 8-bit words |
| fill_up | input | 1 | 0: fill from column 160 down, 1: fill from column 1 up |
| shift_clk | input | 1 | Bus word clock, acts on its falling edge |
| data_in | input | 8 | Parallel display data bus |
| line_pulse | input | 1 | Line transfer pulse, acts on its falling edge |
| disp_on | input | 1 | Low forces all outputs to the off level |
| frame_inv | input | 1 | Frame inversion signal |
| link_a_in | input | 1 | Chain pad A, input value |
| link_a_out | output | 1 | Chain pad A, output value |
| link_a_oe | output | 1 | Chain pad A, drive enable |
| link_b_in | input | 1 | Chain pad B, input value |
| link_b_out | output | 1 | Chain pad B, output value |
| link_b_oe | output | 1 | Chain pad B, drive enable |
| line_bits | output | 160 | Line latch, bit c-1 is column c |
| drive_code | output | 320 | Two bits per column, column c at [2c-1:2c-2] |

## Verification
The hardest case to reach from the ports is the hand-over in a chain: the enable input is low for only one shift period, and the loader must stay selected after it rises again. The same run must also show that the 41st or 21st word is ignored. The stimulus drops the enable input for the first word only and then raises it. It checks the enable output after every word and sends one extra word past the end. The line compare then shows that this word left no trace. Display-off is tested by loading a whole line while the display is off and showing that line only after the next latch pulse.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    LVL_TOP  = 2'd0,
    LVL_MIDH = 2'd1,
    LVL_MIDL = 2'd2,
    LVL_BOT  = 2'd3
  } drive_lvl_e;

  function automatic logic [7:0] flip8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic drive_lvl_e lvl_of(input logic on, input logic fr, input logic d);
    drive_lvl_e l;
    if (!on)            l = LVL_BOT;
    else if (!fr && !d) l = LVL_MIDL;
    else if (!fr &&  d) l = LVL_BOT;
    else if ( fr && !d) l = LVL_MIDH;
    else                l = LVL_TOP;
    return l;
  endfunction

endpackage

// File: rtl/seg_edge_sync.sv
module seg_edge_sync #(
  parameter int STAGES = 2,
  parameter int SIDE_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_in,
  input  logic [SIDE_W-1:0] side_in,
  output logic              fall_o,
  output logic [SIDE_W-1:0] side_o
);
  logic [STAGES-1:0] chain_q;
  logic [SIDE_W-1:0] side_q [STAGES];
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
      for (int i = 0; i < STAGES; i++) side_q[i] <= '0;
    end else begin
      chain_q[0] <= strobe_in;
      side_q[0]  <= side_in;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
        side_q[i]  <= side_q[i-1];
      end
      last_q <= chain_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~chain_q[STAGES-1];
  assign side_o = side_q[STAGES-1];
endmodule

// File: rtl/seg_capture_ctrl.sv
module seg_capture_ctrl import seg_pkg::*; #(
  parameter int COLS = 160
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk_fall,
  input  logic                          lp_fall,
  input  logic                          wide_mode,
  input  logic                          dir_up,
  input  logic                          en_in_n,
  input  logic [7:0]                    din,
  output logic                          wr_en,
  output logic [$clog2(COLS/8)-1:0]     wr_slot,
  output logic [7:0]                    wr_byte,
  output logic                          en_out,
  output logic                          done_o
);
  localparam int BYTES = COLS / 8;
  localparam int IW    = $clog2(BYTES);
  localparam logic [IW-1:0] LAST_IDX = IW'(BYTES - 1);

  logic [IW-1:0] idx_q, idx_n;
  logic          half_q, half_n;
  logic [3:0]    nib_q, nib_n;
  logic          active_q, active_n;
  logic          done_q, done_n;
  logic          eo_low_q, eo_low_n;
  logic          take, byte_rdy, last;
  logic [7:0]    word;

  always_comb begin
    take     = sclk_fall && !done_q && (active_q || !en_in_n);
    word     = wide_mode ? din : {nib_q, din[3:0]};
    byte_rdy = take && (wide_mode || half_q);
    last     = byte_rdy && (idx_q == LAST_IDX);
    idx_n    = idx_q;
    half_n   = half_q;
    nib_n    = nib_q;
    active_n = active_q;
    done_n   = done_q;
    eo_low_n = eo_low_q;
    if (lp_fall) begin
      idx_n    = '0;
      half_n   = 1'b0;
      active_n = 1'b0;
      done_n   = 1'b0;
      eo_low_n = 1'b0;
    end else begin
      if (sclk_fall) eo_low_n = 1'b0;
      if (take) begin
        active_n = 1'b1;
        if (!wide_mode && !half_q) begin
          nib_n  = din[3:0];
          half_n = 1'b1;
        end else begin
          half_n = 1'b0;
          idx_n  = last ? '0 : idx_q + 1'b1;
        end
        if (last) begin
          done_n   = 1'b1;
          active_n = 1'b0;
          eo_low_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      half_q   <= 1'b0;
      nib_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      eo_low_q <= 1'b0;
    end else begin
      idx_q    <= idx_n;
      half_q   <= half_n;
      nib_q    <= nib_n;
      active_q <= active_n;
      done_q   <= done_n;
      eo_low_q <= eo_low_n;
    end
  end

  assign wr_en   = byte_rdy && !lp_fall;
  assign wr_slot = dir_up ? idx_q : LAST_IDX - idx_q;
  assign wr_byte = dir_up ? flip8(word) : word;
  assign en_out  = ~eo_low_q;
  assign done_o  = done_q;
endmodule

// File: rtl/seg_line_store.sv
module seg_line_store #(
  parameter int COLS = 160
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(COLS/8)-1:0] wr_slot,
  input  logic [7:0]                wr_byte,
  input  logic                      lp_fall,
  input  logic                      disp_on_s,
  output logic [COLS-1:0]           dlatch,
  output logic [COLS-1:0]           line_q
);
  localparam int BYTES = COLS / 8;
  localparam int IW    = $clog2(BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlatch <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < BYTES; s++)
        if (wr_slot == IW'(s)) dlatch[8*s +: 8] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          line_q <= '0;
    else if (!disp_on_s) line_q <= '0;
    else if (lp_fall)    line_q <= dlatch;
  end
endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc import seg_pkg::*; #(
  parameter int COLS = 160
) (
  input  logic [COLS-1:0]   line_q,
  input  logic              frame_inv,
  input  logic              disp_on_s,
  output logic [2*COLS-1:0] codes
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign codes[2*c +: 2] = lvl_of(disp_on_s, frame_inv, line_q[c]);
  end
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader #(
  parameter int COLS        = 160,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              width_sel,
  input  logic              fill_up,
  input  logic              shift_clk,
  input  logic [7:0]        data_in,
  input  logic              line_pulse,
  input  logic              disp_on,
  input  logic              frame_inv,
  input  logic              link_a_in,
  output logic              link_a_out,
  output logic              link_a_oe,
  input  logic              link_b_in,
  output logic              link_b_out,
  output logic              link_b_oe,
  output logic [COLS-1:0]   line_bits,
  output logic [2*COLS-1:0] drive_code
);
  localparam int BYTES = COLS / 8;
  localparam int IW    = $clog2(BYTES);

  logic          sclk_fall, lp_fall, disp_on_s, en_in_s;
  logic [7:0]    din_s;
  logic          wr_en, done_w, en_out;
  logic [IW-1:0] wr_slot;
  logic [7:0]    wr_byte;
  logic [COLS-1:0] dlatch;
  logic          en_in_raw;

  assign en_in_raw = fill_up ? link_a_in : link_b_in;

  seg_edge_sync #(.STAGES(SYNC_STAGES), .SIDE_W(9)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .strobe_in(shift_clk),
    .side_in({en_in_raw, data_in}), .fall_o(sclk_fall), .side_o({en_in_s, din_s})
  );

  seg_edge_sync #(.STAGES(SYNC_STAGES), .SIDE_W(1)) u_lp_sync (
    .clk(clk), .rst_n(rst_n), .strobe_in(line_pulse),
    .side_in(disp_on), .fall_o(lp_fall), .side_o(disp_on_s)
  );

  seg_capture_ctrl #(.COLS(COLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .lp_fall(lp_fall),
    .wide_mode(width_sel), .dir_up(fill_up), .en_in_n(en_in_s), .din(din_s),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_byte(wr_byte),
    .en_out(en_out), .done_o(done_w)
  );

  seg_line_store #(.COLS(COLS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_byte(wr_byte),
    .lp_fall(lp_fall), .disp_on_s(disp_on_s), .dlatch(dlatch), .line_q(line_bits)
  );

  seg_level_enc #(.COLS(COLS)) u_enc (
    .line_q(line_bits), .frame_inv(frame_inv), .disp_on_s(disp_on_s), .codes(drive_code)
  );

  assign link_a_oe  = ~fill_up;
  assign link_b_oe  = fill_up;
  assign link_a_out = fill_up ? 1'b1 : en_out;
  assign link_b_out = fill_up ? en_out : 1'b1;
endmodule

// File: rtl/seg_line_loader_chk.sv
module seg_line_loader_chk #(
  parameter int COLS = 160
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk_fall,
  input logic            lp_fall,
  input logic            disp_on_s,
  input logic            wr_en,
  input logic            done_w,
  input logic            en_out,
  input logic [COLS-1:0] dlatch,
  input logic [COLS-1:0] line_bits
);
  AST_WRITE_ON_SHIFT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sclk_fall); // R2

  AST_NO_LOAD_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && !lp_fall) |=> $stable(dlatch)); // R6

  AST_EO_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_out && sclk_fall) |=> en_out); // R7

  AST_EO_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_out) |-> done_w); // R7

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on_s && !lp_fall) |=> $stable(line_bits)); // R8

  AST_BLANK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on_s |=> (line_bits == '0)); // R9
endmodule

bind seg_line_loader seg_line_loader_chk #(.COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .lp_fall(lp_fall),
  .disp_on_s(disp_on_s), .wr_en(wr_en), .done_w(done_w), .en_out(en_out),
  .dlatch(dlatch), .line_bits(line_bits)
);

// File: tb/seg_line_loader_tb_top.sv
module seg_line_loader_tb_top;
  localparam int COLS = 160;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic width_sel = 1'b1, fill_up = 1'b0, shift_clk = 1'b0, line_pulse = 1'b0;
  logic disp_on = 1'b1, frame_inv = 1'b0, link_a_in = 1'b1, link_b_in = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic link_a_out, link_a_oe, link_b_out, link_b_oe;
  logic [COLS-1:0]   line_bits;
  logic [2*COLS-1:0] drive_code;

  always #10 clk = ~clk;

  seg_line_loader dut_i (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .fill_up(fill_up),
    .shift_clk(shift_clk), .data_in(data_in), .line_pulse(line_pulse),
    .disp_on(disp_on), .frame_inv(frame_inv),
    .link_a_in(link_a_in), .link_a_out(link_a_out), .link_a_oe(link_a_oe),
    .link_b_in(link_b_in), .link_b_out(link_b_out), .link_b_oe(link_b_oe),
    .line_bits(line_bits), .drive_code(drive_code)
  );

  int n_run = 0, n_fail = 0;
  typedef struct { logic [COLS-1:0] bits; string tag; } exp_t;
  exp_t sb_q[$];
  event mon_ev;
  logic [COLS-1:0] model = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [2*COLS-1:0] act, input logic [2*COLS-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input logic on, input logic fr, input logic d);
    if (!on) return 2'd3;
    case ({fr, d})
      2'b00: return 2'd2;
      2'b01: return 2'd3;
      2'b10: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  task automatic check_codes(input string req, input logic [COLS-1:0] bits);
    logic [2*COLS-1:0] e;
    for (int c = 0; c < COLS; c++) e[2*c +: 2] = exp_code(disp_on, frame_inv, bits[c]);
    check(drive_code === e, req, "drive codes", drive_code, e);
  endtask

  function automatic logic eo_pin();
    return fill_up ? link_b_out : link_a_out;
  endfunction

  task automatic set_en(input logic v);
    if (fill_up) begin link_a_in = v; link_b_in = 1'b1; end
    else         begin link_b_in = v; link_a_in = 1'b1; end
  endtask

  // Junk on the bus while the clock rises, the real word only before the fall (R2)
  task automatic shift_word(input logic [7:0] d);
    @(negedge clk);
    data_in = ~d;
    shift_clk = 1'b1;
    repeat (2) @(negedge clk);
    data_in = d;
    repeat (HALF - 2) @(negedge clk);
    shift_clk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic place(input int k, input logic [7:0] d, input bit wide, input bit up);
    if (wide) begin
      for (int j = 0; j < 8; j++)
        if (up) model[8*k + 7 - j] = d[j];    // R4
        else    model[152 - 8*k + j] = d[j];  // R3
    end else begin
      for (int j = 0; j < 4; j++)
        if (up) model[4*k + 3 - j] = d[j];    // R4
        else    model[156 - 4*k + j] = d[j];  // R3
    end
  endtask

  task automatic latch_line();
    @(negedge clk);
    line_pulse = 1'b1;
    repeat (HALF) @(negedge clk);
    line_pulse = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic push_expect(input string tag);
    exp_t e;
    e.bits = model;
    e.tag  = tag;
    sb_q.push_back(e);
    latch_line();
    ->mon_ev;
    @(negedge clk);
  endtask

  task automatic load_line(input bit wide, input bit up, input string tag);
    int words;
    words = wide ? 20 : 40;
    width_sel = wide;
    fill_up = up;
    @(negedge clk);
    set_en(1'b0);
    for (int k = 0; k < words; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      shift_word(d);
      place(k, d, wide, up);
      if (k == 0) set_en(1'b1);
      check(eo_pin() === ((k == words - 1) ? 1'b0 : 1'b1), "R1/R7",
            $sformatf("%s enable out after word %0d", tag, k),
            {319'b0, eo_pin()}, {319'b0, (k == words - 1) ? 1'b0 : 1'b1});
    end
    shift_word(8'h5A); // past the end: ignored (R6)
    check(eo_pin() === 1'b1, "R7", {tag, " enable out back high"}, {319'b0, eo_pin()}, 320'd1);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(mon_ev);
      e = sb_q.pop_front();
      check(line_bits === e.bits, e.tag, "line latch", line_bits, e.bits);
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    check(line_bits === '0, "R8", "reset line", line_bits, '0);
    check_codes("R10", '0);
    check(link_a_oe === 1'b1 && link_b_oe === 1'b0 && link_a_out === 1'b1 && link_b_out === 1'b1,
          "R5", "pad roles low dir", {316'b0, link_a_oe, link_b_oe, link_a_out, link_b_out}, 320'hB);

    load_line(1'b1, 1'b0, "R1 R2 R3 R6 8-bit down");
    push_expect("R3");
    check_codes("R10", model);

    // Enable input held high: nothing captured (R11)
    set_en(1'b1);
    for (int k = 0; k < 5; k++) shift_word(8'hC3);
    push_expect("R11");

    load_line(1'b0, 1'b0, "R1 R3 4-bit down");
    push_expect("R3");

    fill_up = 1'b1;
    repeat (2) @(negedge clk);
    check(link_a_oe === 1'b0 && link_b_oe === 1'b1 && link_a_out === 1'b1,
          "R5", "pad roles high dir", {317'b0, link_a_oe, link_b_oe, link_a_out}, 320'h3);

    load_line(1'b1, 1'b1, "R4 8-bit up");
    push_expect("R4");

    load_line(1'b0, 1'b1, "R4 4-bit up");
    push_expect("R4");
    frame_inv = 1'b1;
    @(negedge clk);
    check_codes("R10", model);
    frame_inv = 1'b0;
    @(negedge clk);
    check_codes("R10", model);

    // Display off: cleared and forced, loading continues (R9)
    disp_on = 1'b0;
    repeat (6) @(negedge clk);
    check(line_bits === '0, "R9", "line while off", line_bits, '0);
    check_codes("R9", '0);
    load_line(1'b1, 1'b0, "R9 load while off");
    latch_line();
    check(line_bits === '0, "R9", "latch while off", line_bits, '0);
    disp_on = 1'b1;
    repeat (6) @(negedge clk);
    check(line_bits === '0, "R9", "after release before latch", line_bits, '0);
    check_codes("R9", '0);
    push_expect("R8/R9");
    check_codes("R10", model);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule